// File: doc/BRIEF.md
# Receive Gain Controller with Hold Timer

This block decides whether a receive front end runs in its high-gain state or in its attenuated low-gain state (36 dB less gain). Every clock it takes a digitised signal-strength sample, compares it with two unsigned threshold codes on the same scale and updates a single gain-reduce output. The upper code is greater than the lower code, so the two form an asymmetric hysteresis band.

Entry into low gain happens on the first sample at or above the upper code. Return to high gain is slowed down by a hold timer. The strength must stay below the lower code for 2^k consecutive clock samples, counted in reference-clock cycles. The exponent k is picked by a two-bit mode input, and mode 00 switches the whole function off. Each change of gain state raises a one-cycle strobe, which downstream peak detectors use to restart their tracking.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, gain_low_o is 0 and gain_evt_o is 0, and the hold count is cleared.
- R2: With mode_i = 2'b00 the controller is off. On every clock edge gain_low_o returns to 0 and the hold count clears, whatever the strength value.
- R3: With en_i = 0 the controller is off in the same way as in R2, whatever the mode.
- R4: When the controller is on and in high gain, a sample with strength_i >= HI_CODE sets gain_low_o to 1 at that clock edge.
- R5: When the controller is on and in high gain, a sample with strength_i < HI_CODE leaves gain_low_o at 0. This includes values between the two codes.
- R6: Mode 2'b01, 2'b10 and 2'b11 select k = K_SHORT, K_MED and K_LONG (by default 11, 14 and 20). In low gain, gain_low_o returns to 0 at the edge of the 2^k-th consecutive sample with strength_i < LO_CODE, and not before.
- R7: In low gain, any sample with strength_i >= LO_CODE restarts the hold count from zero and keeps gain_low_o at 1. This includes samples at or above HI_CODE.
- R8: gain_evt_o is 1 for exactly the one cycle in which gain_low_o first shows a new value, and is 0 in every other cycle. This includes changes caused by R2 and R3.
- R9: A mode change during a hold keeps the count. The release then happens when the count of below-threshold samples reaches 2^k of the new mode, or at the next below-threshold sample if the count already exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| mode_i | input | 2 | 00 off, 01/10/11 short/medium/long hold |
| strength_i | input | SW | Signal-strength sample code |
| gain_low_o | output | 1 | 1 selects the attenuated low-gain state |
| gain_evt_o | output | 1 | One-cycle strobe on each gain change |

## Verification
Directed sequences drive samples exactly at HI_CODE, one code below it, exactly at LO_CODE and one code below it. These show whether each comparison is inclusive or strict. Hold runs for every mode stop one sample short of 2^k and then complete it, which catches a timer that ends one cycle early or late. Further runs break a hold with a single sample at the lower code, switch the mode in the middle of a hold, and drop en_i or select mode 00 while in low gain. A long stretch of random enables, modes and strength values, with values biased around both codes, is then compared on every clock against a behavioural model in the bench.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic {
    GAIN_HIGH = 1'b0,
    GAIN_LOW  = 1'b1
  } gain_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_MED   = 2'b10,
    MODE_LONG  = 2'b11
  } mode_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/agc_level_cmp.sv
module agc_level_cmp #(
  parameter int unsigned SW      = 8,
  parameter int unsigned HI_CODE = 200,
  parameter int unsigned LO_CODE = 100
) (
  input  logic [SW-1:0] strength_i,
  output logic          at_hi_o,
  output logic          below_lo_o
);
  localparam logic [SW-1:0] HI = SW'(HI_CODE);
  localparam logic [SW-1:0] LO = SW'(LO_CODE);

  assign at_hi_o    = (strength_i >= HI);
  assign below_lo_o = (strength_i < LO);
endmodule

// File: rtl/agc_dwell_timer.sv
module agc_dwell_timer
  import agc_pkg::*;
#(
  parameter int unsigned K_SHORT = 11,
  parameter int unsigned K_MED   = 14,
  parameter int unsigned K_LONG  = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  input  logic       inc_i,
  output logic       done_o
);
  localparam int unsigned KMAX = max3(K_SHORT, K_MED, K_LONG);
  localparam int unsigned CW   = KMAX;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   last_cnt;

  // terminal count per mode: 2^k - 1
  always_comb begin
    unique case (mode_e'(mode_i))
      MODE_SHORT: last_cnt = ((CW+1)'(1) << K_SHORT) - (CW+1)'(1);
      MODE_MED:   last_cnt = ((CW+1)'(1) << K_MED)   - (CW+1)'(1);
      MODE_LONG:  last_cnt = ((CW+1)'(1) << K_LONG)  - (CW+1)'(1);
      default:    last_cnt = '0;
    endcase
  end

  assign done_o = inc_i && ({1'b0, cnt_q} >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || done_o)   cnt_q <= '0;
    else if (inc_i)             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm
  import agc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic at_hi_i,
  input  logic release_i,
  output logic low_o,
  output logic evt_o
);
  gain_e state_q, state_d;
  logic  evt_q;

  always_comb begin
    state_d = state_q;
    if (!active_i)                                  state_d = GAIN_HIGH;
    else if (state_q == GAIN_HIGH && at_hi_i)       state_d = GAIN_LOW;
    else if (state_q == GAIN_LOW && release_i)      state_d = GAIN_HIGH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GAIN_HIGH;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= (state_d != state_q);
    end
  end

  assign low_o = (state_q == GAIN_LOW);
  assign evt_o = evt_q;
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int unsigned SW      = 8,
  parameter int unsigned HI_CODE = 200,
  parameter int unsigned LO_CODE = 100,
  parameter int unsigned K_SHORT = 11,
  parameter int unsigned K_MED   = 14,
  parameter int unsigned K_LONG  = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic [SW-1:0] strength_i,
  output logic          gain_low_o,
  output logic          gain_evt_o
);
  logic active, at_hi, below_lo, dwell_done, low;

  assign active = en_i && (mode_e'(mode_i) != MODE_OFF);

  agc_level_cmp #(
    .SW(SW), .HI_CODE(HI_CODE), .LO_CODE(LO_CODE)
  ) u_cmp (
    .strength_i (strength_i),
    .at_hi_o    (at_hi),
    .below_lo_o (below_lo)
  );

  // count only while held low with the level under the release code
  agc_dwell_timer #(
    .K_SHORT(K_SHORT), .K_MED(K_MED), .K_LONG(K_LONG)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .clr_i  (!active || !low || !below_lo),
    .inc_i  (active && low && below_lo),
    .done_o (dwell_done)
  );

  agc_gain_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .at_hi_i   (at_hi),
    .release_i (dwell_done),
    .low_o     (low),
    .evt_o     (gain_evt_o)
  );

  assign gain_low_o = low;
endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk #(
  parameter int unsigned SW      = 8,
  parameter int unsigned HI_CODE = 200,
  parameter int unsigned LO_CODE = 100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [1:0]    mode_i,
  input logic [SW-1:0] strength_i,
  input logic          gain_low_o,
  input logic          gain_evt_o
);
  logic on;
  assign on = en_i && (mode_i != 2'b00);

  a_r2_off_forces_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |=> !gain_low_o);

  a_r4_enter_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !gain_low_o && strength_i >= SW'(HI_CODE)) |=> gain_low_o);

  a_r5_stay_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gain_low_o && strength_i < SW'(HI_CODE)) |=> !gain_low_o);

  a_r7_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && gain_low_o && strength_i >= SW'(LO_CODE)) |=> gain_low_o);

  a_r8_evt_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_low_o != $past(gain_low_o)) |-> gain_evt_o);

  a_r8_evt_only_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_evt_o |-> (gain_low_o != $past(gain_low_o)));
endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(
  .SW(SW), .HI_CODE(HI_CODE), .LO_CODE(LO_CODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .mode_i     (mode_i),
  .strength_i (strength_i),
  .gain_low_o (gain_low_o),
  .gain_evt_o (gain_evt_o)
);

// File: tb/agc_gain_ctrl_tb_top.sv
module agc_gain_ctrl_tb_top;
  localparam int SW = 8;
  localparam int HI = 200;
  localparam int LO = 100;
  localparam int KS = 3;
  localparam int KM = 5;
  localparam int KL = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [SW-1:0] str = '0;
  logic          gain_low, gain_evt;

  int    n_chk = 0;
  int    n_err = 0;
  string req = "R1";

  // behavioural reference state
  int m_low = 0;
  int m_evt = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  agc_gain_ctrl #(
    .SW(SW), .HI_CODE(HI), .LO_CODE(LO), .K_SHORT(KS), .K_MED(KM), .K_LONG(KL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .strength_i(str), .gain_low_o(gain_low), .gain_evt_o(gain_evt)
  );

  function automatic int k_of(input logic [1:0] m);
    case (m)
      2'b01:   return KS;
      2'b10:   return KM;
      default: return KL;
    endcase
  endfunction

  task automatic check(input string r, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  // one clock: advance the model with the applied inputs, compare at negedge
  task automatic step();
    int nl;
    @(posedge clk);
    nl = m_low;
    if (!(en && mode != 2'b00)) begin
      nl = 0; m_cnt = 0;
    end else if (m_low == 0) begin
      if (int'(str) >= HI) nl = 1;
      m_cnt = 0;
    end else if (int'(str) >= LO) begin
      m_cnt = 0;
    end else if (m_cnt + 1 >= (1 << k_of(mode))) begin
      nl = 0; m_cnt = 0;
    end else begin
      m_cnt++;
    end
    m_evt = (nl != m_low) ? 1 : 0;
    m_low = nl;
    @(negedge clk);
    check(req, int'(gain_low), m_low, "gain_low_o");
    check(req, int'(gain_evt), m_evt, "gain_evt_o");
  endtask

  task automatic drive(input logic e, input logic [1:0] m, input int s);
    en = e; mode = m; str = SW'(s);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #40000000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    req = "R1";
    repeat (3) @(negedge clk);
    check("R1", int'(gain_low), 0, "gain_low_o in reset");
    check("R1", int'(gain_evt), 0, "gain_evt_o in reset");
    rst_n = 1'b1;
    steps(2);

    // R2 mode off ignores strong signal
    req = "R2"; drive(1, 2'b00, 255); steps(4);
    // R3 disabled ignores strong signal
    req = "R3"; drive(0, 2'b11, 255); steps(4);

    // R5 just below upper code stays high
    req = "R5"; drive(1, 2'b01, HI-1); steps(3);
    check("R5", int'(gain_low), 0, "one code below upper");

    // R4 exactly at upper code
    req = "R4"; drive(1, 2'b01, HI); step();
    check("R4", int'(gain_low), 1, "entry at upper code");
    check("R8", int'(gain_evt), 1, "strobe on entry");
    req = "R8"; step();
    check("R8", int'(gain_evt), 0, "strobe lasts one cycle");

    // R6 hold length per mode
    for (int mi = 1; mi < 4; mi++) begin
      req = "R6";
      drive(1, 2'(mi), HI); steps(2);
      drive(1, 2'(mi), LO-1);
      steps((1 << k_of(2'(mi))) - 1);
      check("R6", int'(gain_low), 1, "still low one sample short");
      step();
      check("R6", int'(gain_low), 0, "released after 2^k samples");
      check("R8", int'(gain_evt), 1, "strobe on release");
    end

    // R7 sample at lower code restarts count; strong sample keeps low
    req = "R7"; drive(1, 2'b01, HI); steps(2);
    drive(1, 2'b01, LO-1); steps((1 << KS) - 1);
    drive(1, 2'b01, LO); step();
    drive(1, 2'b01, LO-1); steps((1 << KS) - 1);
    check("R7", int'(gain_low), 1, "count restarted by sample at lower code");
    drive(1, 2'b01, 255); steps(3);
    check("R7", int'(gain_low), 1, "strong sample while low");
    drive(1, 2'b01, LO-1); steps(1 << KS);
    check("R7", int'(gain_low), 0, "release after fresh count");

    // R9 mode change mid-hold to shorter mode
    req = "R9"; drive(1, 2'b11, HI); steps(2);
    drive(1, 2'b11, 0); steps(20);
    drive(1, 2'b01, 0); step();
    check("R9", int'(gain_low), 0, "count already past shorter hold");
    drive(1, 2'b01, HI); steps(2);
    drive(1, 2'b01, 0); steps(3);
    drive(1, 2'b10, 0); steps((1 << KM) - 4);
    check("R9", int'(gain_low), 1, "one short of longer hold");
    step();
    check("R9", int'(gain_low), 0, "released at longer hold");

    // R2/R3 leaving low gain when switched off
    req = "R3"; drive(1, 2'b10, HI); steps(2);
    drive(0, 2'b10, HI); step();
    check("R3", int'(gain_low), 0, "disable forces high");
    check("R8", int'(gain_evt), 1, "strobe on disable");
    req = "R2"; drive(1, 2'b10, HI); steps(2);
    drive(1, 2'b00, 0); step();
    check("R2", int'(gain_low), 0, "mode off forces high");
    drive(1, 2'b01, LO-1); steps(3);
    check("R2", int'(gain_low), 0, "count cleared while off");

    // random stretch against the model
    req = "R6";
    for (int i = 0; i < 4000; i++) begin
      int r;
      int s;
      r = $urandom_range(0, 99);
      s = (r < 40) ? $urandom_range(0, LO-1) :
          (r < 60) ? $urandom_range(LO, HI-1) :
          (r < 70) ? $urandom_range(HI, 255) :
          (r < 85) ? LO - 1 + $urandom_range(0, 1) : HI - 1 + $urandom_range(0, 1);
      drive(($urandom_range(0, 49) != 0), ($urandom_range(0, 39) == 0) ? 2'($urandom_range(0, 3)) : mode, s);
      if (mode == 2'b00 && $urandom_range(0, 3) != 0) mode = 2'b01;
      step();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule